// File: doc/BRIEF.md
# Offset-Based Tick Register

This block presents a 64-bit tick register that software can read and write, while the actual timekeeping is done by a free-running 63-bit counter that advances on each cycle where the count enable is high. A write never loads that counter. The block records how far the written value sits from the live count, and holds the written most significant bit (a flag that makes the register unreadable by non-privileged code) in its own flip-flop.

A read adds the stored offset to the live count. It returns bits 62 down to 2 of that sum, with the two lowest bits forced to zero and bit 63 taken from the stored flag. The register appears under two aliased names, the tick and the system tick. Each name has its own write strobe, and both strobes update the same state. The read path is combinational from registered state, so a write becomes visible on the cycle after its strobe.

Top module: `tick_offset_reg`

## Requirements
- R1: In the cycle after a write of D with count enable low, the read data bits 62:2 equal D bits 62:2. When counting continues for k more cycles, those bits equal ((D[62:0] + k) mod 2^63) bits 62:2.
- R2: Read data bits 1:0 are always zero, whatever value was written.
- R3: After reset the read data is 64'h8000_0000_0000_0000: the stored flag is 1, the offset is 0 and the count is 0.
- R4: Read data bit 63 equals bit 63 of the last written value and is never changed by counting, even when the 63-bit sum wraps.
- R5: A strobe on the tick alias (wr_tick_i) and a strobe on the system tick alias (wr_stick_i) store identical state, and both strobes in one cycle act as a single write.
- R6: The running count rises by one on each clock edge where cnt_en_i is 1, holds when it is 0, and wraps modulo 2^63. With no write and count enable low, the read data does not change.
- R7: In the cycle in which a write strobe is high, the read data still shows the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Advances the running count by one this cycle |
| wr_tick_i | input | 1 | Write strobe through the tick alias |
| wr_stick_i | input | 1 | Write strobe through the system tick alias |
| wr_data_i | input | 64 | Value to write |
| rd_data_o | output | 64 | Current register value |

## Verification
The assertions assume that count enable and the write strobes are clean, synchronous levels. The readback property further assumes that count enable is low in the write cycle, so that the sum on the next cycle equals the written value exactly. The bench keeps count enable low for every table write and for the same-cycle test. Writes made while counting, including one placed just below the 63-bit wrap point, are checked only against the bench's own cycle count.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned CNT_W    = DATA_W - 1;
  localparam int unsigned LOW_ZERO = 2;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/tick_run_cnt.sv
module tick_run_cnt #(
  parameter int unsigned W = tick_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o + W'(1);   // wraps mod 2^W
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_o == $past(cnt_o) + W'(1)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o)); // R6
endmodule

// File: rtl/tick_ofs_reg.sv
module tick_ofs_reg #(
  parameter int unsigned DW = tick_pkg::DATA_W,
  localparam int unsigned W = DW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic [W-1:0]  cnt_i,
  output logic [W-1:0]  ofs_o,
  output logic          top_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_o <= '0;
      top_o <= 1'b1;
    end else if (wr_i) begin
      ofs_o <= data_i[W-1:0] - cnt_i;
      top_o <= data_i[DW-1];
    end
  end

  AST_TOP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> top_o == $past(data_i[DW-1])); // R4
  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ofs_o) && $stable(top_o)); // R4
endmodule

// File: rtl/tick_rd_path.sv
module tick_rd_path #(
  parameter int unsigned DW = tick_pkg::DATA_W,
  parameter int unsigned LZ = tick_pkg::LOW_ZERO,
  localparam int unsigned W = DW - 1
) (
  input  logic [W-1:0]  cnt_i,
  input  logic [W-1:0]  ofs_i,
  input  logic          top_i,
  output logic [DW-1:0] rd_o
);
  logic [W-1:0] sum;
  always_comb begin
    sum  = cnt_i + ofs_i;
    rd_o = {top_i, sum[W-1:LZ], {LZ{1'b0}}};
  end
endmodule

// File: rtl/tick_offset_reg.sv
module tick_offset_reg #(
  parameter int unsigned DATA_W   = tick_pkg::DATA_W,
  parameter int unsigned LOW_ZERO = tick_pkg::LOW_ZERO,
  localparam int unsigned CNT_W   = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              wr_tick_i,
  input  logic              wr_stick_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic             wr;
  logic [CNT_W-1:0] cnt, ofs;
  logic             top;

  // both alias names reach the same state
  assign wr = wr_tick_i | wr_stick_i;

  tick_run_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en_i), .cnt_o(cnt)
  );

  tick_ofs_reg #(.DW(DATA_W)) u_ofs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .data_i(wr_data_i),
    .cnt_i(cnt), .ofs_o(ofs), .top_o(top)
  );

  tick_rd_path #(.DW(DATA_W), .LZ(LOW_ZERO)) u_rd (
    .cnt_i(cnt), .ofs_i(ofs), .top_i(top), .rd_o(rd_data_o)
  );

  AST_WR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !cnt_en_i) |=> rd_data_o[DATA_W-2:LOW_ZERO] == $past(wr_data_i[DATA_W-2:LOW_ZERO])); // R1
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[LOW_ZERO-1:0] == '0); // R2
  AST_TOP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> rd_data_o[DATA_W-1] == $past(wr_data_i[DATA_W-1])); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && !cnt_en_i) |=> $stable(rd_data_o)); // R6
endmodule

// File: tb/tick_offset_reg_tb_top.sv
module tick_offset_reg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic        wr_tick_i = 1'b0;
  logic        wr_stick_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [63:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tick_offset_reg dut_i (.*);

  // {alias select (0 tick, 1 system tick), data}
  localparam logic [64:0] VEC [8] = '{
    {1'b0, 64'h0123_4567_89AB_CDEF},
    {1'b1, 64'hFEDC_BA98_7654_3210},
    {1'b0, 64'h7FFF_FFFF_FFFF_FFFF},
    {1'b1, 64'h8000_0000_0000_0003},
    {1'b0, 64'h0000_0000_0000_0001},
    {1'b1, 64'hA5A5_A5A5_5A5A_5A5A},
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFE},
    {1'b1, 64'h0000_0000_0000_0000}
  };

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] masked(input logic [63:0] d);
    return {d[63:2], 2'b00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] prev;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk("R3 reset value", rd_data_o, 64'h8000_0000_0000_0000);

    // R6: ten counting cycles, then hold
    cnt_en_i = 1'b1;
    repeat (10) step();
    cnt_en_i = 1'b0;
    chk("R6 count by ten", rd_data_o, 64'h8000_0000_0000_0008);
    step();
    chk("R6 hold when disabled", rd_data_o, 64'h8000_0000_0000_0008);

    // table walk: R1 R2 R4 R5
    for (int i = 0; i < 8; i++) begin
      wr_tick_i  = ~VEC[i][64];
      wr_stick_i =  VEC[i][64];
      wr_data_i  =  VEC[i][63:0];
      step();
      wr_tick_i  = 1'b0;
      wr_stick_i = 1'b0;
      chk(VEC[i][64] ? "R1 R2 R4 R5 system tick alias write" : "R1 R2 R4 R5 tick alias write",
          rd_data_o, masked(VEC[i][63:0]));
    end

    // R7: read in write cycle shows old value
    prev = rd_data_o;
    wr_tick_i = 1'b1;
    wr_data_i = 64'h1111_2222_3333_4447;
    #1;
    chk("R7 old value in write cycle", rd_data_o, prev);
    step();
    wr_tick_i = 1'b0;
    chk("R1 R2 new value after write", rd_data_o, 64'h1111_2222_3333_4444);

    // R5: both strobes together
    wr_tick_i  = 1'b1;
    wr_stick_i = 1'b1;
    wr_data_i  = 64'h8765_4321_0FED_CBA9;
    step();
    wr_tick_i  = 1'b0;
    wr_stick_i = 1'b0;
    chk("R5 both strobes", rd_data_o, 64'h8765_4321_0FED_CBA8);

    // R1 R6: write while counting, wrap of the 63-bit sum
    cnt_en_i  = 1'b1;
    wr_tick_i = 1'b1;
    wr_data_i = 64'h7FFF_FFFF_FFFF_FFFC;
    step();
    wr_tick_i = 1'b0;
    chk("R1 one count after write", rd_data_o, 64'h7FFF_FFFF_FFFF_FFFC);
    repeat (3) step();
    cnt_en_i = 1'b0;
    chk("R6 wrap after four counts", rd_data_o, 64'h0000_0000_0000_0000);

    // R4: flag survives wrap of the sum
    wr_stick_i = 1'b1;
    wr_data_i  = 64'hFFFF_FFFF_FFFF_FFF0;
    step();
    wr_stick_i = 1'b0;
    cnt_en_i   = 1'b1;
    repeat (16) step();
    cnt_en_i = 1'b0;
    chk("R4 flag kept across wrap", rd_data_o, 64'h8000_0000_0000_0000);
    step();
    chk("R2 low bits zero", {62'd0, rd_data_o[1:0]}, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule